// File: doc/BRIEF.md
# Main-Objective-Biased Binary Tournament Selector

This block settles binary tournaments for a multi-objective evolutionary search engine. Each request presents two candidates. A candidate carries an index, three objective scores (functional quality, area score and speed score, where a higher value is better) and a precomputed Pareto-strength fitness, where a lower value is better. One cycle after the request, the block reports which candidate won.

In the biased mode, the first rule compares the two candidates on one chosen main objective, and the strictly higher score wins. If the main objective does not decide, or in plain mode where that rule is skipped, the lower strength fitness wins. An exact tie goes to the lower index. This pushes the search toward the main objective and still lets Pareto ranking break ties.

Parent selection takes a configured number of back-to-back tournaments. The block keeps a running champion across the round winners, using the same rules. On the last round it reports a parent together with that round's winner. Random candidate indices and all fitness arithmetic come from outside the block.

Top module: `pareto_tourney`

## Requirements
- R1: While `rst_n` is low on a clock edge, `win_valid` and `parent_valid` go low on that edge, and the round position clears, so the next request is round one of a new parent selection.
- R2: Each cycle with `req_valid` high gives `win_valid` high on the next cycle, with `win_idx` equal to that request's `a_idx` or `b_idx`. A cycle without a request gives `win_valid` low on the next cycle.
- R3: With `mode_main` = 1, a candidate whose main objective score is strictly higher wins, whatever the fitness values.
- R4: `main_sel` picks the main objective inside each 3*OBJ_W-bit objective vector: 0 picks quality in bits [OBJ_W-1:0], 1 picks area in bits [2*OBJ_W-1:OBJ_W], 2 picks speed in bits [3*OBJ_W-1:2*OBJ_W], and 3 acts as 0.
- R5: With `mode_main` = 0, the objective vectors have no effect and the strictly lower fitness wins. With `mode_main` = 1 and equal main scores, the strictly lower fitness also wins.
- R6: When neither the main-objective rule nor the fitness comparison decides, the candidate with the lower index wins. Equal indices report candidate A.
- R7: On every ROUNDS-th request since reset, `parent_valid` is high in the same cycle as `win_valid`. `parent_idx` is then the winner of a running comparison across the round winners. Each comparison uses the rules of R3 to R6, with the earlier champion as side A and the mode and `main_sel` of the request that produced the newer winner.
- R8: On all other result cycles and idle cycles, `parent_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A tournament request is present this cycle |
| mode_main | input | 1 | 1 = main objective first, 0 = plain fitness tournament |
| main_sel | input | 2 | Main objective select (0 quality, 1 area, 2 speed, 3 as 0) |
| a_idx | input | IDX_W | Index of candidate A |
| a_obj | input | 3*OBJ_W | Objective vector of candidate A (speed, area, quality from MSB) |
| a_fit | input | FIT_W | Strength fitness of candidate A, lower is better |
| b_idx | input | IDX_W | Index of candidate B |
| b_obj | input | 3*OBJ_W | Objective vector of candidate B |
| b_fit | input | FIT_W | Strength fitness of candidate B |
| win_valid | output | 1 | Tournament result strobe |
| win_idx | output | IDX_W | Index of the tournament winner |
| parent_valid | output | 1 | Parent chosen after the final round |
| parent_idx | output | IDX_W | Index of the chosen parent |

## Verification
The assertions assume that the inputs are stable and defined on every clock edge while `rst_n` is high. They also assume that the request fields are meaningful only in cycles with `req_valid` high. The stimulus drives all inputs on the falling edge, so every rising edge sees settled values. It draws objective scores, fitness values and indices from narrow ranges, so that main-objective ties, fitness ties and equal indices all occur often. Idle gaps of random length separate requests, and the stimulus switches mode and `main_sel` between the rounds of one parent selection, so that the champion comparison uses the settings of the newer round.

// File: rtl/tnm_pkg.sv
// Package: shared encodings for the tournament selector.
// Assumes a 2-bit raw select, where the unused code folds onto quality.
package tnm_pkg;

    typedef enum logic [1:0] {
        SEL_QUAL  = 2'd0,
        SEL_AREA  = 2'd1,
        SEL_SPEED = 2'd2
    } obj_sel_e;

    // Fold the raw select code onto a legal objective (code 3 -> quality)
    function automatic obj_sel_e decode_sel(input logic [1:0] raw);
        case (raw)
            2'd1:    decode_sel = SEL_AREA;
            2'd2:    decode_sel = SEL_SPEED;
            default: decode_sel = SEL_QUAL;
        endcase
    endfunction

endpackage

// File: rtl/tnm_key_pick.sv
// Module: extracts the score of the selected objective from a packed vector.
// Assumes the vector holds quality, area and speed from the LSB upward, each OBJ_W wide.
module tnm_key_pick #(
    parameter int OBJ_W = 8
) (
    input  logic [3*OBJ_W-1:0]   obj,
    input  tnm_pkg::obj_sel_e    sel,
    output logic [OBJ_W-1:0]     key
);

    logic [OBJ_W-1:0] field [3];

    // Slice the three objective fields out of the packed vector
    for (genvar g = 0; g < 3; g++) begin : g_field
        assign field[g] = obj[g*OBJ_W +: OBJ_W];
    end

    // Route the selected field to the key output
    always_comb begin
        case (sel)
            tnm_pkg::SEL_AREA:  key = field[1];
            tnm_pkg::SEL_SPEED: key = field[2];
            default:            key = field[0];
        endcase
    end

endmodule

// File: rtl/tnm_judge.sv
// Module: decides one pairwise contest between side A and side B.
// Order of rules: main objective (higher wins, only when main_en), then fitness
// (lower wins), then index (lower wins, equal goes to A). Purely combinational.
module tnm_judge #(
    parameter int OBJ_W = 8,
    parameter int FIT_W = 10,
    parameter int IDX_W = 6
) (
    input  logic                 main_en,
    input  tnm_pkg::obj_sel_e    sel,
    input  logic [IDX_W-1:0]     a_idx,
    input  logic [3*OBJ_W-1:0]   a_obj,
    input  logic [FIT_W-1:0]     a_fit,
    input  logic [IDX_W-1:0]     b_idx,
    input  logic [3*OBJ_W-1:0]   b_obj,
    input  logic [FIT_W-1:0]     b_fit,
    output logic [OBJ_W-1:0]     key_a,
    output logic [OBJ_W-1:0]     key_b,
    output logic                 a_wins
);

    tnm_key_pick #(.OBJ_W(OBJ_W)) u_pick_a (.obj(a_obj), .sel(sel), .key(key_a));
    tnm_key_pick #(.OBJ_W(OBJ_W)) u_pick_b (.obj(b_obj), .sel(sel), .key(key_b));

    // Apply the three rules in priority order
    always_comb begin
        if (main_en && (key_a != key_b)) begin
            a_wins = (key_a > key_b);
        end else if (a_fit != b_fit) begin
            a_wins = (a_fit < b_fit);
        end else begin
            a_wins = (a_idx <= b_idx);
        end
    end

endmodule

// File: rtl/pareto_tourney.sv
// Module: top of the tournament selector. Registers each round's winner one
// cycle after the request and keeps a running champion across ROUNDS rounds.
// On the last round it also registers the parent.
// Assumes the inputs are valid whenever req_valid is high. ROUNDS >= 1.
module pareto_tourney #(
    parameter int OBJ_W  = 8,
    parameter int FIT_W  = 10,
    parameter int IDX_W  = 6,
    parameter int ROUNDS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 mode_main,
    input  logic [1:0]           main_sel,
    input  logic [IDX_W-1:0]     a_idx,
    input  logic [3*OBJ_W-1:0]   a_obj,
    input  logic [FIT_W-1:0]     a_fit,
    input  logic [IDX_W-1:0]     b_idx,
    input  logic [3*OBJ_W-1:0]   b_obj,
    input  logic [FIT_W-1:0]     b_fit,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output logic                 parent_valid,
    output logic [IDX_W-1:0]     parent_idx
);

    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

    tnm_pkg::obj_sel_e    sel_dec;
    logic                 pair_a_wins;
    logic [OBJ_W-1:0]     pair_key_a, pair_key_b;

    logic [IDX_W-1:0]     rw_idx;
    logic [3*OBJ_W-1:0]   rw_obj;
    logic [FIT_W-1:0]     rw_fit;

    logic [CNT_W-1:0]     round_q;
    logic [IDX_W-1:0]     champ_idx_q;
    logic [3*OBJ_W-1:0]   champ_obj_q;
    logic [FIT_W-1:0]     champ_fit_q;

    logic [IDX_W-1:0]     next_champ_idx;
    logic [3*OBJ_W-1:0]   next_champ_obj;
    logic [FIT_W-1:0]     next_champ_fit;

    logic                 last_round;

    // Fold the raw main-objective select onto a legal code
    assign sel_dec    = tnm_pkg::decode_sel(main_sel);
    assign last_round = (round_q == LAST_RND);

    tnm_judge #(.OBJ_W(OBJ_W), .FIT_W(FIT_W), .IDX_W(IDX_W)) u_pair (
        .main_en (mode_main),
        .sel     (sel_dec),
        .a_idx   (a_idx),
        .a_obj   (a_obj),
        .a_fit   (a_fit),
        .b_idx   (b_idx),
        .b_obj   (b_obj),
        .b_fit   (b_fit),
        .key_a   (pair_key_a),
        .key_b   (pair_key_b),
        .a_wins  (pair_a_wins)
    );

    // Select the full record of this round's winner
    always_comb begin
        if (pair_a_wins) begin
            rw_idx = a_idx;
            rw_obj = a_obj;
            rw_fit = a_fit;
        end else begin
            rw_idx = b_idx;
            rw_obj = b_obj;
            rw_fit = b_fit;
        end
    end

    // Champion merge: a single round needs none, more rounds compare with the stored champion
    if (ROUNDS > 1) begin : g_multi
        logic fin_a_wins;
        logic [OBJ_W-1:0] fin_key_a, fin_key_b;

        tnm_judge #(.OBJ_W(OBJ_W), .FIT_W(FIT_W), .IDX_W(IDX_W)) u_final (
            .main_en (mode_main),
            .sel     (sel_dec),
            .a_idx   (champ_idx_q),
            .a_obj   (champ_obj_q),
            .a_fit   (champ_fit_q),
            .b_idx   (rw_idx),
            .b_obj   (rw_obj),
            .b_fit   (rw_fit),
            .key_a   (fin_key_a),
            .key_b   (fin_key_b),
            .a_wins  (fin_a_wins)
        );

        // First round seeds the champion, later rounds keep the better record
        always_comb begin
            if ((round_q != '0) && fin_a_wins) begin
                next_champ_idx = champ_idx_q;
                next_champ_obj = champ_obj_q;
                next_champ_fit = champ_fit_q;
            end else begin
                next_champ_idx = rw_idx;
                next_champ_obj = rw_obj;
                next_champ_fit = rw_fit;
            end
        end
    end else begin : g_single
        // With one round the round winner is the parent
        always_comb begin
            next_champ_idx = rw_idx;
            next_champ_obj = rw_obj;
            next_champ_fit = rw_fit;
        end
    end

    // Round position and stored champion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_q     <= '0;
            champ_idx_q <= '0;
            champ_obj_q <= '0;
            champ_fit_q <= '0;
        end else if (req_valid) begin
            round_q     <= last_round ? '0 : round_q + CNT_W'(1);
            champ_idx_q <= next_champ_idx;
            champ_obj_q <= next_champ_obj;
            champ_fit_q <= next_champ_fit;
        end
    end

    // Registered tournament result and parent outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid    <= 1'b0;
            win_idx      <= '0;
            parent_valid <= 1'b0;
            parent_idx   <= '0;
        end else begin
            win_valid    <= req_valid;
            parent_valid <= req_valid && last_round;
            if (req_valid) begin
                win_idx <= rw_idx;
            end
            if (req_valid && last_round) begin
                parent_idx <= next_champ_idx;
            end
        end
    end

    AST_WIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> win_valid);                                                 // R2
    AST_NO_SPURIOUS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !win_valid);                                               // R2
    AST_WIN_FROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (win_idx == $past(a_idx) || win_idx == $past(b_idx)));      // R2
    AST_MAIN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_main && (pair_key_a > pair_key_b)) |=> (win_idx == $past(a_idx))); // R3
    AST_PLAIN_FITNESS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_main && (a_fit < b_fit)) |=> (win_idx == $past(a_idx)));          // R5
    AST_PARENT_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        parent_valid |-> win_valid);                                              // R7
    AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        round_q <= LAST_RND);                                                     // R7

endmodule

// File: tb/tb_pareto_tourney.sv
module tb_pareto_tourney;

    localparam int CLK_PERIOD = 10;
    localparam int OBJ_W  = 8;
    localparam int FIT_W  = 10;
    localparam int IDX_W  = 6;
    localparam int ROUNDS = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 mode_main = 1'b0;
    logic [1:0]           main_sel = 2'd0;
    logic [IDX_W-1:0]     a_idx = '0, b_idx = '0;
    logic [3*OBJ_W-1:0]   a_obj = '0, b_obj = '0;
    logic [FIT_W-1:0]     a_fit = '0, b_fit = '0;
    logic                 win_valid, parent_valid;
    logic [IDX_W-1:0]     win_idx, parent_idx;

    int checks = 0;
    int failures = 0;

    // Reference model state
    int exp_wv = 0, exp_wi = 0, exp_pv = 0, exp_pi = 0;
    int m_round = 0;
    int ch_idx = 0, ch_fit = 0;
    logic [3*OBJ_W-1:0] ch_obj = '0;
    string cur_tag = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    pareto_tourney #(.OBJ_W(OBJ_W), .FIT_W(FIT_W), .IDX_W(IDX_W), .ROUNDS(ROUNDS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_main(mode_main),
        .main_sel(main_sel), .a_idx(a_idx), .a_obj(a_obj), .a_fit(a_fit),
        .b_idx(b_idx), .b_obj(b_obj), .b_fit(b_fit),
        .win_valid(win_valid), .win_idx(win_idx),
        .parent_valid(parent_valid), .parent_idx(parent_idx)
    );

    function automatic int score(input logic [3*OBJ_W-1:0] v, input int s);
        int f;
        f = (s == 1 || s == 2) ? s : 0;
        return int'((v >> (OBJ_W * f)) & {OBJ_W{1'b1}});
    endfunction

    // Returns 1 when side A wins under the stated rules
    function automatic int ref_a_wins(input int md, input int s,
                                      input logic [3*OBJ_W-1:0] ao, input int af, input int ai,
                                      input logic [3*OBJ_W-1:0] bo, input int bf, input int bi);
        int ka, kb;
        ka = score(ao, s);
        kb = score(bo, s);
        if (md != 0 && ka != kb) return (ka > kb) ? 1 : 0;
        if (af != bf) return (af < bf) ? 1 : 0;
        return (ai <= bi) ? 1 : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs with the model; runs every falling edge
    task automatic compare_outputs();
        check("R2 win_valid", int'(win_valid), exp_wv);
        if (exp_wv != 0) check({cur_tag, " win_idx"}, int'(win_idx), exp_wi);
        if (exp_pv != 0) begin
            check("R7 parent_valid", int'(parent_valid), 1);
            check("R7 parent_idx", int'(parent_idx), exp_pi);
        end else begin
            check("R8 parent_valid", int'(parent_valid), 0);
        end
    endtask

    // One cycle: check last results, then drive new inputs and update the model
    task automatic step(input string tag, input int v, input int md, input int s,
                        input int ai, input logic [3*OBJ_W-1:0] ao, input int af,
                        input int bi, input logic [3*OBJ_W-1:0] bo, input int bf);
        int wa, wi, wf, ca;
        logic [3*OBJ_W-1:0] wo;
        @(negedge clk);
        compare_outputs();
        cur_tag = tag;
        req_valid = (v != 0); mode_main = (md != 0); main_sel = 2'(s);
        a_idx = IDX_W'(ai); a_obj = ao; a_fit = FIT_W'(af);
        b_idx = IDX_W'(bi); b_obj = bo; b_fit = FIT_W'(bf);
        exp_wv = v; exp_pv = 0;
        if (v != 0) begin
            wa = ref_a_wins(md, s, ao, af, ai, bo, bf, bi);
            wi = wa ? ai : bi; wo = wa ? ao : bo; wf = wa ? af : bf;
            exp_wi = wi;
            if (m_round == 0) begin
                ch_idx = wi; ch_obj = wo; ch_fit = wf;
            end else begin
                ca = ref_a_wins(md, s, ch_obj, ch_fit, ch_idx, wo, wf, wi);
                if (ca == 0) begin
                    ch_idx = wi; ch_obj = wo; ch_fit = wf;
                end
            end
            if (m_round == ROUNDS - 1) begin
                exp_pv = 1; exp_pi = ch_idx; m_round = 0;
            end else begin
                m_round++;
            end
        end
    endtask

    function automatic logic [3*OBJ_W-1:0] mk(input int q, input int ar, input int sp);
        return {OBJ_W'(sp), OBJ_W'(ar), OBJ_W'(q)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Reset held with a request pending: outputs stay low (R1)
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 win_valid in reset", int'(win_valid), 0);
        check("R1 parent_valid in reset", int'(parent_valid), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 win_valid after reset", int'(win_valid), 0);

        // R3: better quality wins despite worse fitness
        step("R3", 1, 1, 0, 3, mk(200, 1, 1), 900, 5, mk(100, 9, 9), 1);
        // R5: plain mode ignores objectives, lower fitness wins
        step("R5", 1, 0, 0, 3, mk(200, 1, 1), 900, 5, mk(100, 9, 9), 1);
        step("R2", 0, 0, 0, 0, '0, 0, 0, '0, 0);
        // R4: area select
        step("R4", 1, 1, 1, 7, mk(1, 50, 0), 500, 8, mk(99, 40, 99), 2);
        // R4: speed select
        step("R4", 1, 1, 2, 7, mk(99, 99, 10), 2, 8, mk(0, 0, 11), 500);
        // R4: code 3 behaves as quality
        step("R4", 1, 1, 3, 1, mk(30, 0, 0), 700, 2, mk(20, 90, 90), 3);
        // R5: equal main score, fitness decides
        step("R5", 1, 1, 0, 1, mk(40, 0, 0), 9, 2, mk(40, 0, 0), 8);
        // R6: full tie, lower index wins
        step("R6", 1, 1, 0, 9, mk(40, 5, 5), 8, 4, mk(40, 5, 5), 8);
        step("R6", 1, 0, 0, 2, mk(1, 1, 1), 8, 11, mk(1, 1, 1), 8);
        step("R8", 0, 0, 0, 0, '0, 0, 0, '0, 0);
        step("R8", 0, 0, 0, 0, '0, 0, 0, '0, 0);

        // Randomised stream with narrow ranges for frequent ties
        for (int i = 0; i < 3000; i++) begin
            int v;
            v = ($urandom_range(0, 3) != 0) ? 1 : 0;
            step("R6", v, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 7)),
                 mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3))),
                 int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 7)),
                 mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3))),
                 int'($urandom_range(0, 3)));
        end
        step("R2", 0, 0, 0, 0, '0, 0, 0, '0, 0);
        @(negedge clk);
        compare_outputs();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule